// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block is the slave side of a three-wire serial EEPROM. A host frames each command with chip select. On a rising edge of the serial clock the block takes the first data-in high as a start bit. It then shifts in a two-bit opcode, an address and, for the storing commands, one data word. It runs the command against an internal word-wide register array. Reads return a word on the data-out pin. Erase and write commands start a self-timed operation, and the block reports its progress on data-out as ready or busy.

The block runs on a system clock. The serial clock, chip select and data-in are sampled on that clock, and each rising serial-clock edge is detected from them. A power-up lock blocks every storing command until an enable command has run. The length of a storing operation is a parameter counted in system clocks. The data-out pin is modelled as a value plus an output enable, and a low enable stands for high impedance.

Top module: `eeprom3w_slave`

## Requirements
- R1: After reset the block is locked against erase and write, waits for a start bit, and holds the data-out enable low.
- R2: While chip select is high, data-in lows before the first data-in high are ignored, and that first high is the start bit.
- R3: Opcode 10 is a read. On the rising edge that loads the last address bit, data-out is driven to a dummy 0. The next 16 rising edges present the stored word most significant bit first, so a read takes 27 clocks with 8 address bits.
- R4: Opcode 01 is a write that takes 16 data bits after the address. Once the operation completes, the addressed word holds the data.
- R5: Opcode 11 is an erase. Once it completes, the addressed word is all ones.
- R6: For opcode 00 the top two address bits select the command: 11 enables storing, 00 disables it, 10 sets every word to all ones, and 01 stores the 16 received data bits into every word.
- R7: While locked, after reset or after a disable, write, erase, erase-all and write-all leave the array unchanged and never drive the busy status.
- R8: After an accepted storing command, data-out is enabled while chip select is high. It reads 0 for BUSY_CYC system clocks and 1 afterwards. A start bit sent during that time is ignored.
- R9: With chip select low the data-out enable is low. Dropping chip select in the middle of an instruction aborts it without effect.
- R10: Once an instruction is complete, further clocks and data-in are ignored until chip select goes low.
- R11: An enable stays in force across any number of storing commands until a disable or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out value |
| dout_oe_o | output | 1 | Data-out drive enable, low means high impedance |

## Verification
The bench keeps the defaults of 8 address bits and 16-bit words, so every one of the 256 words is reachable by the random traffic. It lowers BUSY_CYC to 300 system clocks. That is long enough for a whole 27-bit read frame to be sent while a write is still running, which makes the ignored start bit observable. It is also short enough for dozens of storing commands to fit in one run.

// File: rtl/eeprom3w_slave.sv
module eeprom3w_slave #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int BUSY_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic dout_o,
  output logic dout_oe_o
);
  localparam int WORDS = 1 << AW;
  localparam int MAXB  = (AW > DW) ? AW : DW;
  localparam int BCW   = $clog2(MAXB + 1);
  localparam int TW    = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_DAT, S_RD, S_DONE} st_t;
  typedef enum logic [1:0] {K_WR, K_ER, K_ERAL, K_WRAL} kind_t;

  st_t             st;
  kind_t           kind, l_kind;
  logic            sk_q, en_q, busy_q, show_rb, dout_q;
  logic [BCW-1:0]  bcnt;
  logic [1:0]      opc;
  logic [AW-1:0]   adr, p_adr;
  logic [DW-1:0]   dat, p_dat, rd_sh;
  logic [TW-1:0]   tmr;
  logic [DW-1:0]   mem [WORDS];

  wire sk_rise  = sk_i & ~sk_q;
  wire edge_ok  = sk_rise & cs_i;
  wire [AW-1:0] adr_full = {adr[AW-2:0], di_i};
  wire [DW-1:0] dat_full = {dat[DW-2:0], di_i};
  wire [1:0] ext_sel  = adr_full[AW-1:AW-2];
  wire last_adr = edge_ok && st == S_ADR && bcnt == BCW'(AW - 1);
  wire last_dat = edge_ok && st == S_DAT && bcnt == BCW'(DW - 1);
  wire launch   = en_q && (last_dat ||
                  (last_adr && (opc == 2'b11 || (opc == 2'b00 && ext_sel == 2'b10))));
  wire finish   = busy_q && tmr == '0;

  assign l_kind    = last_dat ? ((opc == 2'b01) ? K_WR : K_WRAL)
                              : ((opc == 2'b11) ? K_ER : K_ERAL);
  assign dout_oe_o = cs_i && (st == S_RD || (show_rb && (st == S_IDLE || st == S_DONE)));
  assign dout_o    = (st == S_RD) ? dout_q : ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; opc <= '0; adr <= '0; dat <= '0;
      rd_sh <= '0; dout_q <= 1'b0; en_q <= 1'b0; show_rb <= 1'b0;
    end else if (!cs_i) begin
      st <= S_IDLE; bcnt <= '0;
    end else if (sk_rise) begin
      case (st)
        S_IDLE: if (di_i && !busy_q) begin
          st <= S_OPC; bcnt <= '0; show_rb <= 1'b0;
        end
        S_OPC: begin
          opc  <= {opc[0], di_i};
          bcnt <= (bcnt == BCW'(1)) ? '0 : bcnt + 1'b1;
          if (bcnt == BCW'(1)) st <= S_ADR;
        end
        S_ADR: begin
          adr  <= adr_full;
          bcnt <= bcnt + 1'b1;
          if (last_adr) begin
            bcnt <= '0;
            st   <= S_DONE;
            case (opc)
              2'b10: begin st <= S_RD; rd_sh <= mem[adr_full]; dout_q <= 1'b0; end
              2'b01: st <= S_DAT;
              2'b00: case (ext_sel)
                2'b11: en_q <= 1'b1;
                2'b00: en_q <= 1'b0;
                2'b01: st <= S_DAT;
                default: ;
              endcase
              default: ;
            endcase
          end
        end
        S_DAT: begin
          dat  <= dat_full;
          bcnt <= bcnt + 1'b1;
          if (last_dat) begin bcnt <= '0; st <= S_DONE; end
        end
        S_RD: begin
          if (bcnt == BCW'(DW)) st <= S_DONE;
          else begin
            dout_q <= rd_sh[DW-1];
            rd_sh  <= {rd_sh[DW-2:0], 1'b0};
            bcnt   <= bcnt + 1'b1;
          end
        end
        default: ;
      endcase
      if (launch) show_rb <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; tmr <= '0; kind <= K_WR; p_adr <= '0; p_dat <= '0;
    end else if (launch) begin
      busy_q <= 1'b1; tmr <= TW'(BUSY_CYC - 1); kind <= l_kind;
      p_adr  <= last_dat ? adr : adr_full;
      p_dat  <= dat_full;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (launch && l_kind == K_WR) mem[adr] <= '1;
    if (finish) begin
      case (kind)
        K_WR: mem[p_adr] <= p_dat;
        K_ER: mem[p_adr] <= '1;
        K_ERAL: for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        K_WRAL: for (int i = 0; i < WORDS; i++) mem[i] <= p_dat;
      endcase
    end
  end

  p_lock_no_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !busy_q) |=> !busy_q);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tmr != '0) |=> busy_q);
  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && st == S_IDLE) |=> st == S_IDLE);
  p_abort_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> st == S_IDLE);
  p_hiz_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> !dout_oe_o);
  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && cs_i) |=> (st == S_DONE || !$past(cs_i) || !cs_i));
  p_rd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RD |-> bcnt <= BCW'(DW));
endmodule

// File: tb/eeprom3w_slave_tb.sv
module eeprom3w_slave_tb;
  localparam int CLK_NS = 10;
  localparam int BUSY   = 300;

  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0;
  logic dout, dout_oe, s_oe, s_do;
  int total = 0, bad = 0;
  logic [15:0] exp_mem [256];
  logic exp_en = 0;

  always #(CLK_NS/2) clk = ~clk;

  eeprom3w_slave #(.AW(8), .DW(16), .BUSY_CYC(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .dout_o(dout), .dout_oe_o(dout_oe));

  function automatic logic [7:0] ext_adr(input logic [1:0] sel);
    return {sel, 6'b101010};
  endfunction

  function automatic logic accepts(input logic [1:0] op, input logic [7:0] a, input logic en);
    return en && (op == 2'b01 || op == 2'b11 || (op == 2'b00 && (a[7:6] == 2'b10 || a[7:6] == 2'b01)));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk) di = b;
    repeat (2) @(negedge clk);
    sk = 1;
    repeat (3) @(negedge clk);
    s_oe = dout_oe; s_do = dout;
    sk = 0;
  endtask

  task automatic cs_off();
    @(negedge clk) cs = 0; di = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                       input int lead0, output logic [15:0] rd);
    @(negedge clk) cs = 1;
    repeat (lead0) send(1'b0);
    send(1'b1); send(op[1]); send(op[0]);
    for (int i = 7; i >= 0; i--) send(a[i]);
    rd = '0;
    if (op == 2'b10) begin
      chk(s_oe && !s_do, "R3 dummy zero", {s_oe, s_do}, 2'b10);
      for (int i = 0; i < 16; i++) begin
        send(1'b0);
        rd = {rd[14:0], s_do};
      end
    end
    if (op == 2'b01 || (op == 2'b00 && a[7:6] == 2'b01))
      for (int i = 15; i >= 0; i--) send(d[i]);
  endtask

  task automatic finish_mod(input logic acc, input logic chk_len);
    int n;
    if (acc) begin
      chk(s_oe && !s_do, "R8 busy reads 0", {s_oe, s_do}, 2'b10);
      n = 0;
      while (!(dout_oe && dout) && n < BUSY + 50) begin @(negedge clk); n++; end
      if (chk_len) chk(n >= BUSY - 8 && n <= BUSY, "R8 busy length", n, BUSY);
    end else begin
      chk(!s_oe, "R7 no status while locked", s_oe, 0);
    end
    cs_off();
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    if (op == 2'b00) begin
      case (a[7:6])
        2'b11: exp_en = 1;
        2'b00: exp_en = 0;
        2'b10: if (exp_en) for (int i = 0; i < 256; i++) exp_mem[i] = 16'hFFFF;
        2'b01: if (exp_en) for (int i = 0; i < 256; i++) exp_mem[i] = d;
      endcase
    end else if (exp_en && op == 2'b01) exp_mem[a] = d;
    else if (exp_en && op == 2'b11) exp_mem[a] = 16'hFFFF;
  endtask

  task automatic run(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    logic [15:0] rd;
    logic acc;
    acc = accepts(op, a, exp_en);
    issue(op, a, d, 0, rd);
    if (op == 2'b10) begin
      chk(rd == exp_mem[a], "R3 read data", rd, exp_mem[a]);
      cs_off();
    end else if (op == 2'b00 && (a[7:6] == 2'b11 || a[7:6] == 2'b00)) begin
      chk(!s_oe, "R6 enable/disable leaves data-out off", s_oe, 0);
      cs_off();
    end else finish_mod(acc, 1);
    apply(op, a, d);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    logic [15:0] rd;
    issue(2'b10, a, 16'h0, 0, rd);
    chk(rd == exp_mem[a], req, rd, exp_mem[a]);
    cs_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int seed;
    seed = $urandom(32'h5EED);
    repeat (5) @(negedge clk);
    chk(!dout_oe, "R1 reset data-out off", dout_oe, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 / R7: locked after reset
    issue(2'b01, 8'd3, 16'h1234, 0, rd); finish_mod(0, 0);
    issue(2'b11, 8'd3, 16'h0, 0, rd);    finish_mod(0, 0);
    run(2'b00, ext_adr(2'b11), 16'h0);
    run(2'b00, ext_adr(2'b10), 16'h0);
    rd_chk(8'd0, "R6 erase-all word 0");
    rd_chk(8'd200, "R6 erase-all word 200");
    run(2'b01, 8'd3, 16'h1234);
    rd_chk(8'd3, "R4 write then read");
    run(2'b11, 8'd3, 16'h0);
    rd_chk(8'd3, "R5 erase gives ones");
    run(2'b00, ext_adr(2'b00), 16'h0);
    run(2'b00, ext_adr(2'b01), 16'hA3C6);
    rd_chk(8'd9, "R7 write-all blocked");
    run(2'b01, 8'd9, 16'h0F0F);
    rd_chk(8'd9, "R7 write blocked after disable");
    run(2'b00, ext_adr(2'b10), 16'h0);
    run(2'b00, ext_adr(2'b11), 16'h0);
    run(2'b00, ext_adr(2'b01), 16'hA3C6);
    rd_chk(8'd0, "R6 write-all word 0");
    rd_chk(8'd255, "R6 write-all word 255");
    rd_chk(8'd17, "R6 write-all word 17");
    run(2'b01, 8'd5, 16'h5A01);
    run(2'b01, 8'd6, 16'h5A02);
    run(2'b01, 8'd7, 16'h5A03);
    rd_chk(8'd5, "R11 enable persists 1");
    rd_chk(8'd7, "R11 enable persists 3");

    // R8: start bit ignored while busy
    issue(2'b01, 8'd40, 16'hBEEF, 0, rd);
    chk(s_oe && !s_do, "R8 busy after write", {s_oe, s_do}, 2'b10);
    apply(2'b01, 8'd40, 16'hBEEF);
    cs_off();
    @(negedge clk) cs = 1;
    send(1'b1); send(1'b1); send(1'b0);
    for (int i = 7; i >= 0; i--) send(1'b0);
    chk(s_oe && !s_do, "R8 start ignored while busy", {s_oe, s_do}, 2'b10);
    for (int i = 0; i < 10; i++) send(1'b1);
    chk(s_oe && !s_do, "R8 still status not read data", {s_oe, s_do}, 2'b10);
    begin
      int n = 0;
      while (!(dout_oe && dout) && n < BUSY + 50) begin @(negedge clk); n++; end
      chk(dout_oe && dout, "R8 ready after busy", {dout_oe, dout}, 2'b11);
    end
    cs_off();
    rd_chk(8'd40, "R4 write committed after busy");

    // R10: trailing bits after enable ignored
    @(negedge clk) cs = 1;
    send(1'b1); send(1'b0); send(1'b0);
    for (int i = 7; i >= 0; i--) send(ext_adr(2'b11)[i]);
    send(1'b1); send(1'b0); send(1'b1);
    for (int i = 7; i >= 0; i--) send(i == 0 || i == 2);
    for (int i = 0; i < 16; i++) send(1'b0);
    chk(!s_oe, "R10 trailing bits no action", s_oe, 0);
    cs_off();
    rd_chk(8'd5, "R10 word 5 unchanged");

    // R9: abort by chip select
    @(negedge clk) cs = 1;
    send(1'b1); send(1'b0); send(1'b1);
    for (int i = 0; i < 5; i++) send(1'b0);
    cs_off();
    chk(!dout_oe, "R9 data-out off with cs low", dout_oe, 0);
    repeat (BUSY + 20) @(negedge clk);
    rd_chk(8'd0, "R9 partial write had no effect");

    // R2: leading zeros before start bit
    issue(2'b10, 8'd6, 16'h0, 3, rd);
    chk(rd == exp_mem[6], "R2 leading zeros ignored", rd, exp_mem[6]);
    cs_off();

    for (int it = 0; it < 45; it++) begin
      int r = $urandom % 9;
      logic [7:0] a = 8'($urandom);
      logic [15:0] d = 16'($urandom);
      case (r)
        0, 1, 2: run(2'b01, a, d);
        3:       run(2'b11, a, d);
        4, 7, 8: run(2'b10, a, d);
        5:       run(2'b00, ext_adr(2'b11), d);
        default: run(2'b00, ext_adr(2'b00), d);
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule